// File: doc/BRIEF.md
# Three-Level Interrupt Entry Sequencer

This block sits beside an execution core and decides when and how the core enters an exception handler. It watches three active-low request lines: a non-maskable line, a fast line and a normal line. Each line passes through a synchronizer, and only a falling edge counts as a request. The block holds two mask flags, one for the fast level and one for the normal level. It picks the most urgent request that is allowed through and then offers one entry to the core. The entry carries the source code, the handler vector address and the kind of register frame the core must push.

The entry is offered on a valid/ready channel. `ent_valid` rises when an entry is ready to start. `ent_src`, `ent_vector` and `ent_frame` hold still until the core raises `ent_ready`, which the core does once its stacking sequence has finished. On that handshake the block does three things: it sets both mask flags, it updates the entire-frame flag, and it drops the serviced request. The core may stall the channel for any number of cycles, and new edges keep arriving and waiting during the stall. The core writes the mask flags through a plain write port. For example, it clears the fast mask inside a normal handler so that fast requests can preempt that handler. Leaving reset, the block presents a reset entry before anything else.

Top module: `intr_entry_seq`

## Requirements
- R1: When more than one request is pending and allowed, the entry offered is the non-maskable one first, then the fast one, then the normal one. Source codes are 0 for reset, 1 for non-maskable, 2 for fast and 3 for normal.
- R2: A request is raised only by a high-to-low transition of its line, seen after a two-flop synchronizer. Holding a line low produces exactly one entry.
- R3: An edge on the normal line is discarded while `mask_i` is 1, and a normal entry is never started while `mask_i` is 1.
- R4: An edge on the fast line is discarded while `mask_f` is 1, and a fast entry is never started while `mask_f` is 1.
- R5: Reset sets `mask_i` and `mask_f` to 1. Every accepted entry sets both of them to 1.
- R6: A fast entry has frame code 1 (program counter and condition codes only). Its acceptance clears `eflag`.
- R7: Normal and non-maskable entries have frame code 2 (full register set). Their acceptance sets `eflag`.
- R8: After reset the first entry offered has source 0, vector 16'hFFFE and frame code 0, and `eflag` reads 0.
- R9: The vectors are 16'hFFFC for the non-maskable source, 16'hFFFA for the fast source and 16'hFFF8 for the normal source.
- R10: While `ent_valid` is 1 and `ent_ready` is 0, the entry fields hold still. A handshake clears only the pending request it serviced. An edge captured in the handshake cycle, even on the same line, stays pending.
- R11: A non-maskable entry is started while both masks are 1, so it preempts a fast handler. A fast entry is started during a normal handler once the core has cleared `mask_f`.
- R12: A pulse on `mask_we` loads `mask_wdata` (bit 1 into `mask_f`, bit 0 into `mask_i`). If an entry is accepted in the same cycle, the entry wins and both masks become 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request line, active low, edge sensitive |
| firq_n | input | 1 | Fast request line, active low, edge sensitive |
| irq_n | input | 1 | Normal request line, active low, edge sensitive |
| mask_we | input | 1 | Mask write strobe from the core |
| mask_wdata | input | 2 | New mask values, {fast, normal} |
| ent_ready | input | 1 | Core has finished stacking for the offered entry |
| ent_valid | output | 1 | An entry is offered |
| ent_src | output | 2 | Source of the offered entry |
| ent_vector | output | 16 | Address of the handler vector word |
| ent_frame | output | 2 | Frame to push: 0 none, 1 partial, 2 full |
| eflag | output | 1 | Entire-frame flag for the return logic |
| mask_i | output | 1 | Normal-level mask flag |
| mask_f | output | 1 | Fast-level mask flag |

## Verification
Two pairs of events can land in the same clock edge. In the first pair, a request edge on a line reaches its pending flag in the very edge where an entry from that same line is accepted. The bench provokes this by timing a fresh non-maskable edge two cycles before raising `ent_ready`. It then judges the result by whether a second non-maskable entry follows. In the second pair, a mask write coincides with an entry handshake, and the bench judges the result by reading both masks as 1 right afterwards. A sweep over every mask setting combined with every set of simultaneously falling lines predicts the order of entries, their vectors and their frames arithmetically.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int NUM_LINES = 3;
  localparam int SRC_W     = 2;
  localparam int FRAME_W   = 2;

  localparam logic [SRC_W-1:0] SRC_RESET = 2'd0;
  localparam logic [SRC_W-1:0] SRC_NMI   = 2'd1;
  localparam logic [SRC_W-1:0] SRC_FAST  = 2'd2;
  localparam logic [SRC_W-1:0] SRC_NORM  = 2'd3;

  localparam logic [FRAME_W-1:0] FRM_NONE = 2'd0;
  localparam logic [FRAME_W-1:0] FRM_PART = 2'd1;
  localparam logic [FRAME_W-1:0] FRM_FULL = 2'd2;
endpackage

// File: rtl/intr_seq_edge.sv
module intr_seq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic fall
);
  // sh[0..STAGES-1] synchronize; sh[STAGES] remembers the previous synced value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], line_n};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/intr_seq_pick.sv
module intr_seq_pick
  import intr_seq_pkg::*;
(
  input  logic [NUM_LINES-1:0] pend,
  input  logic                 mask_i,
  input  logic                 mask_f,
  output logic                 hit,
  output logic [SRC_W-1:0]     src
);
  logic [NUM_LINES-1:0] elig;

  // index 0 = non-maskable, 1 = fast, 2 = normal
  assign elig = {pend[2] & ~mask_i, pend[1] & ~mask_f, pend[0]};
  assign hit  = |elig;

  always_comb begin
    src = SRC_RESET;
    for (int k = NUM_LINES - 1; k >= 0; k--) begin
      if (elig[k]) src = SRC_W'(k + 1);
    end
  end
endmodule

// File: rtl/intr_seq_plan.sv
module intr_seq_plan
  import intr_seq_pkg::*;
#(
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = {{(VEC_W-1){1'b1}}, 1'b0}
) (
  input  logic [SRC_W-1:0]   src,
  output logic [VEC_W-1:0]   vector,
  output logic [FRAME_W-1:0] frame,
  output logic               set_e,
  output logic               clr_e
);
  localparam int WORD_BYTES = 2;

  // one vector word per source, stepping down from the reset vector
  assign vector = RESET_VEC - VEC_W'(WORD_BYTES * int'(src));

  always_comb begin
    frame = FRM_NONE;
    set_e = 1'b0;
    clr_e = 1'b0;
    case (src)
      SRC_NMI, SRC_NORM: begin frame = FRM_FULL; set_e = 1'b1; end
      SRC_FAST:          begin frame = FRM_PART; clr_e = 1'b1; end
      default:           frame = FRM_NONE;
    endcase
  end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_seq_pkg::*;
#(
  parameter int               VEC_W       = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] RESET_VEC   = {{(VEC_W-1){1'b1}}, 1'b0}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_n,
  input  logic             firq_n,
  input  logic             irq_n,
  input  logic             mask_we,
  input  logic [1:0]       mask_wdata,
  input  logic             ent_ready,
  output logic             ent_valid,
  output logic [1:0]       ent_src,
  output logic [VEC_W-1:0] ent_vector,
  output logic [1:0]       ent_frame,
  output logic             eflag,
  output logic             mask_i,
  output logic             mask_f
);
  logic [NUM_LINES-1:0] line_n, fall, allow, clr, pend;
  logic                 hit, set_e, clr_e, accept;
  logic [SRC_W-1:0]     pick_src;

  assign line_n = {irq_n, firq_n, nmi_n};
  assign allow  = {~mask_i, ~mask_f, 1'b1};
  assign accept = ent_valid & ent_ready;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    intr_seq_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .line_n(line_n[g]),
      .fall  (fall[g])
    );
    assign clr[g] = accept && (ent_src == SRC_W'(g + 1));
  end

  intr_seq_pick u_pick (
    .pend  (pend),
    .mask_i(mask_i),
    .mask_f(mask_f),
    .hit   (hit),
    .src   (pick_src)
  );

  intr_seq_plan #(.VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) u_plan (
    .src   (ent_src),
    .vector(ent_vector),
    .frame (ent_frame),
    .set_e (set_e),
    .clr_e (clr_e)
  );

  // pending requests: a new edge wins over the clear of the same line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | (fall & allow);
  end

  // entry channel: reset entry first, then arbitrated entries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= 1'b1;
      ent_src   <= SRC_RESET;
    end else if (accept) begin
      ent_valid <= 1'b0;
    end else if (!ent_valid && hit) begin
      ent_valid <= 1'b1;
      ent_src   <= pick_src;
    end
  end

  // mask and entire-frame flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_i <= 1'b1;
      mask_f <= 1'b1;
      eflag  <= 1'b0;
    end else if (accept) begin
      mask_i <= 1'b1;
      mask_f <= 1'b1;
      if (set_e)      eflag <= 1'b1;
      else if (clr_e) eflag <= 1'b0;
    end else if (mask_we) begin
      mask_f <= mask_wdata[1];
      mask_i <= mask_wdata[0];
    end
  end
endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = {{(VEC_W-1){1'b1}}, 1'b0}
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_we,
  input logic [1:0]       mask_wdata,
  input logic             ent_ready,
  input logic             ent_valid,
  input logic [1:0]       ent_src,
  input logic [VEC_W-1:0] ent_vector,
  input logic [1:0]       ent_frame,
  input logic             eflag,
  input logic             mask_i,
  input logic             mask_f
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_src) && $stable(ent_vector) && $stable(ent_frame)); // R10
  AST_MASKS_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_ready |=> mask_i && mask_f); // R5
  AST_FAST_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_src == 2'd2 |-> ent_frame == 2'd1); // R6
  AST_FAST_CLEARS_E: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_ready && ent_src == 2'd2 |=> !eflag); // R6
  AST_FULL_SETS_E: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_ready && (ent_src == 2'd1 || ent_src == 2'd3) |=> eflag && ent_frame != 2'd1); // R7
  AST_NORMAL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ent_valid) && ent_src == 2'd3 |-> !$past(mask_i)); // R3
  AST_FAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ent_valid) && ent_src == 2'd2 |-> !$past(mask_f)); // R4
  AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_src == 2'd0 |-> ent_vector == RESET_VEC && ent_frame == 2'd0); // R8
  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_src == 2'd1 |-> ent_vector == RESET_VEC - VEC_W'(2)); // R9
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we && !(ent_valid && ent_ready) |=> {mask_f, mask_i} == $past(mask_wdata)); // R12
endmodule

bind intr_entry_seq intr_entry_seq_chk #(.VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
  .ent_ready(ent_ready), .ent_valid(ent_valid), .ent_src(ent_src),
  .ent_vector(ent_vector), .ent_frame(ent_frame), .eflag(eflag),
  .mask_i(mask_i), .mask_f(mask_f)
);

// File: tb/intr_entry_seq_test.sv
`timescale 1ns/1ps
module intr_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_n = 1'b1, firq_n = 1'b1, irq_n = 1'b1;
  logic        mask_we = 1'b0;
  logic [1:0]  mask_wdata = 2'b00;
  logic        ent_ready = 1'b0;
  logic        ent_valid;
  logic [1:0]  ent_src, ent_frame;
  logic [15:0] ent_vector;
  logic        eflag, mask_i, mask_f;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  intr_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .firq_n(firq_n), .irq_n(irq_n),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .ent_ready(ent_ready),
    .ent_valid(ent_valid), .ent_src(ent_src), .ent_vector(ent_vector),
    .ent_frame(ent_frame), .eflag(eflag), .mask_i(mask_i), .mask_f(mask_f)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic set_masks(input logic [1:0] v);
    mask_we = 1'b1; mask_wdata = v;
    tick(1);
    mask_we = 1'b0;
  endtask

  task automatic accept();
    ent_ready = 1'b1;
    tick(1);
    ent_ready = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    bit ok = 0;
    for (int i = 0; i < 16; i++) begin
      if (ent_valid) begin ok = 1; break; end
      tick(1);
    end
    chk(req, "entry offered", 32'(ok), 32'd1);
  endtask

  // expected fields of one entry, computed from the requirement encodings
  task automatic expect_entry(input string req, input int s);
    wait_valid(req);
    chk(req, "source", 32'(ent_src), 32'(s));
    chk("R9", "vector", 32'(ent_vector), 32'(16'hFFFE - 2 * s));
    chk(s == 2 ? "R6" : "R7", "frame", 32'(ent_frame), (s == 2) ? 32'd1 : 32'd2);
    accept();
    chk("R5", "masks after entry", {30'd0, mask_f, mask_i}, 32'd3);
    chk(s == 2 ? "R6" : "R7", "eflag", 32'(eflag), (s == 2) ? 32'd0 : 32'd1);
  endtask

  task automatic expect_idle(input string req, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (ent_valid) seen = 1;
      tick(1);
    end
    chk(req, "no entry", 32'(seen), 32'd0);
  endtask

  task automatic pulse(input int line);
    if (line == 1) nmi_n = 1'b0; else if (line == 2) firq_n = 1'b0; else irq_n = 1'b0;
    tick(4);
    nmi_n = 1'b1; firq_n = 1'b1; irq_n = 1'b1;
    tick(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R8 and R5: reset state and reset entry
    chk("R8", "reset valid", 32'(ent_valid), 32'd1);
    chk("R8", "reset source", 32'(ent_src), 32'd0);
    chk("R8", "reset vector", 32'(ent_vector), 32'hFFFE);
    chk("R8", "reset frame", 32'(ent_frame), 32'd0);
    chk("R8", "reset eflag", 32'(eflag), 32'd0);
    chk("R5", "reset masks", {30'd0, mask_f, mask_i}, 32'd3);
    accept();
    expect_idle("R2", 6);

    // sweep: every mask setting against every set of simultaneous falling lines
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        logic [1:0] mm = 2'(m);
        logic [2:0] cc = 3'(c);
        logic [2:0] p;
        logic mi, mf;
        set_masks(mm);
        chk("R12", "mask write", {30'd0, mask_f, mask_i}, 32'(mm));
        nmi_n = ~cc[0]; firq_n = ~cc[1]; irq_n = ~cc[2];
        mi = mm[0]; mf = mm[1];
        p = {cc[2] & ~mi, cc[1] & ~mf, cc[0]};   // R3 R4: masked edges are dropped
        tick(5);
        while (p != 3'b000) begin
          int s;
          if (p[0]) s = 1;                        // R1 priority
          else if (p[1] && !mf) s = 2;
          else if (p[2] && !mi) s = 3;
          else s = 0;
          if (s == 0) begin
            set_masks(2'b00); mi = 0; mf = 0;
            continue;
          end
          expect_entry("R1", s);
          p[s-1] = 1'b0;
          mi = 1; mf = 1;
        end
        expect_idle("R2", 6);                     // held low: no repeat
        nmi_n = 1'b1; firq_n = 1'b1; irq_n = 1'b1;
        expect_idle("R2", 4);                     // rising edge: no request
      end
    end

    // R10: held entry stays stable, and an edge arriving meanwhile waits
    set_masks(2'b00);
    irq_n = 1'b0;
    wait_valid("R10");
    nmi_n = 1'b0;
    tick(6);
    chk("R10", "held valid", 32'(ent_valid), 32'd1);
    chk("R10", "held source", 32'(ent_src), 32'd3);
    chk("R10", "held vector", 32'(ent_vector), 32'hFFF8);
    accept();
    expect_entry("R10", 1);
    nmi_n = 1'b1; irq_n = 1'b1;
    tick(4);

    // R10 and R12: same-line edge and a mask write both land on the accept edge
    pulse(1);
    wait_valid("R10");
    nmi_n = 1'b0;            // before edge k
    tick(1);                 // after k
    tick(1);                 // after k+1
    ent_ready = 1'b1; mask_we = 1'b1; mask_wdata = 2'b00;
    tick(1);                 // accept and pend set at k+2
    ent_ready = 1'b0; mask_we = 1'b0;
    chk("R12", "entry beats mask write", {30'd0, mask_f, mask_i}, 32'd3);
    expect_entry("R10", 1);
    nmi_n = 1'b1;
    expect_idle("R10", 6);

    // R3: a normal edge while masked is discarded for good
    pulse(3);
    set_masks(2'b00);
    expect_idle("R3", 8);
    set_masks(2'b11);

    // R4 and R11: preemption chain normal -> fast -> non-maskable
    set_masks(2'b00);
    pulse(3);
    expect_entry("R11", 3);
    pulse(2);
    expect_idle("R4", 8);
    set_masks(2'b01);        // core clears the fast mask inside the normal handler
    expect_idle("R4", 6);
    pulse(2);
    expect_entry("R11", 2);
    pulse(1);
    expect_entry("R11", 1);
    expect_idle("R11", 6);

    finish_run();
  end
endmodule